// File: doc/BRIEF.md
# Interleaved 4:2:2 Video Word Stream Generator

This block produces the byte stream that feeds a digital video encoder chip at standard-definition interlaced rates. It runs on a 27 MHz clock and emits exactly one 8-bit word on every cycle. It never pauses. The block keeps a word counter within each line and a line counter within each frame. From those two counters it decides, word by word, what goes on the bus:

- a timing reference code,
- a blanking value, or
- a byte of picture data.

Line and field timing travel inside the data itself as reserved code sequences. There are no separate sync pins.

Picture data comes from an upstream frame-buffer reader, one pixel pair (32 bits) at a time, through a request/valid exchange:

- **Request.** `pix_req` acts as the block's ready signal. It pulses for one cycle, one cycle before the pair is needed.
- **Response.** Upstream answers with `pix_valid` and `pix_data` in the following cycle.
- **No back-pressure.** The output timing is fixed, so the block cannot wait for upstream and upstream cannot hold the block off.
- **Late pair.** If upstream misses its slot, that pair is shown as black and the stream stays on time.
- **Unsolicited data.** `pix_valid` outside a response slot is ignored.

With default parameters a line is 1716 words and a frame is 525 lines:

| Line section | Words | Position in line |
|---|---|---|
| Start-of-active code | 4 | 0–3 |
| Active words | 1440 | from 4 |
| End-of-active code | 4 | directly after the active words |
| Blanking | remainder | to end of line |

Top module: `vid_stream_gen`

## Requirements
- R1: `dbg_samp`/`dbg_line` give the line position and frame line of the word currently on `vid_data`. `dbg_samp` advances by one every clock and wraps from WORDS_PER_LINE-1 to 0. On that wrap `dbg_line` advances, and it wraps from LINES_PER_FRAME-1 to 0.
- R2: While `rst` is high the outputs are as follows: `vid_data`=0x10, `dbg_samp`=WORDS_PER_LINE-1, `dbg_line`=LINES_PER_FRAME-1 and `pix_req`=0. The first word after reset is line 0, position 0.
- R3: Line positions 0..3 carry the start code 0xFF, 0x00, 0x00, status. Positions ACTIVE_WORDS+4 .. ACTIVE_WORDS+7 carry the end code with the same four-word layout.
- R4: The status word bits, from bit 7 down to bit 0, are 1, F, V, H, V^H, F^H, F^V, F^V^H. H is 0 in the start code and 1 in the end code.
- R5: F is 1 on lines at or above FIELD2_FIRST_LINE and 0 otherwise. V is 0 on lines inside [F1_VIS_FIRST, F1_VIS_LAST] or [F2_VIS_FIRST, F2_VIS_LAST], and 1 on all other lines.
- R6: Every non-code word of a V=1 line, and every word after the end code of any line, is 0x80 at even positions and 0x10 at odd positions.
- R7: `pix_req` is high exactly in the cycles where `dbg_samp` = 4k+2, for k = 0 .. ACTIVE_WORDS/4-1, on V=0 lines.
- R8: A pair is taken from `pix_data` when `pix_valid` is high in the cycle after `pix_req`. It is sent as `pix_data[31:24]` (Cr), `[23:16]` (Y), `[15:8]` (Cb), `[7:0]` (Y) at positions 4k+4 .. 4k+7. `pix_valid` in any other cycle has no effect on the output.
- R9: If `pix_valid` is low in a response cycle, the four words of that pair are 0x80, 0x10, 0x80, 0x10, and all timing is unchanged.
- R10: A pixel byte of 0x00 is sent as 0x01 and a pixel byte of 0xFF is sent as 0xFE. As a result, 0x00 and 0xFF appear only inside timing codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one output word per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_req | output | 1 | Ready pulse: a pixel pair is wanted in the next cycle |
| pix_valid | input | 1 | Upstream pair present in the cycle after `pix_req` |
| pix_data | input | 32 | Pixel pair {Cr, Y0, Cb, Y1} |
| vid_data | output | 8 | Multiplexed video word stream |
| dbg_line | output | $clog2(LINES_PER_FRAME) | Frame line of the current word |
| dbg_samp | output | $clog2(WORDS_PER_LINE) | Line position of the current word |

## Verification
The hardest case to reach is a pixel pair whose response slot is empty while `pix_valid` pulses in neighbouring cycles. Only the exact slot cycle may matter, and the stream must keep its timing. The bench uses a small raster of 40-word lines and 10-line frames. It sweeps three full frames word by word:

- **First frame:** upstream answers every request.
- **Second frame:** upstream skips a computed pattern of slots and raises unsolicited `pix_valid` with reserved-code data in other cycles.

Every frame also carries pairs made of 0x00 and 0xFF bytes, which exercises the substitution rule.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  localparam logic [7:0] CODE_HI = 8'hFF;
  localparam logic [7:0] CODE_LO = 8'h00;
  localparam logic [7:0] BLANK_C = 8'h80;
  localparam logic [7:0] BLANK_Y = 8'h10;

  typedef enum logic [1:0] {
    RG_SAV   = 2'd0,
    RG_ACT   = 2'd1,
    RG_EAV   = 2'd2,
    RG_BLANK = 2'd3
  } region_e;

  // timing status byte with protection bits
  function automatic logic [7:0] status_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // keep picture bytes out of the reserved code values
  function automatic logic [7:0] clip_byte(input logic [7:0] b);
    if (b == CODE_LO) return 8'h01;
    if (b == CODE_HI) return 8'hFE;
    return b;
  endfunction

endpackage

// File: rtl/vsg_raster.sv
module vsg_raster
  import vsg_pkg::*;
#(
  parameter int WORDS_PER_LINE     = 1716,
  parameter int ACTIVE_WORDS       = 1440,
  parameter int LINES_PER_FRAME    = 525,
  parameter int FIELD2_FIRST_LINE  = 263,
  parameter int F1_VIS_FIRST       = 19,
  parameter int F1_VIS_LAST        = 261,
  parameter int F2_VIS_FIRST       = 281,
  parameter int F2_VIS_LAST        = 524,
  localparam int SW = $clog2(WORDS_PER_LINE),
  localparam int LW = $clog2(LINES_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] samp,
  output logic [LW-1:0] line,
  output logic          fld,
  output logic          vblk,
  output region_e       region,
  output logic [1:0]    code_idx
);

  logic samp_last, line_last;

  assign samp_last = (samp == SW'(WORDS_PER_LINE - 1));
  assign line_last = (line == LW'(LINES_PER_FRAME - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      samp <= '0;
      line <= '0;
    end else begin
      samp <= samp_last ? '0 : samp + 1'b1;
      if (samp_last) line <= line_last ? '0 : line + 1'b1;
    end
  end

  assign fld  = (line >= LW'(FIELD2_FIRST_LINE));
  assign vblk = !(((line >= LW'(F1_VIS_FIRST)) && (line <= LW'(F1_VIS_LAST))) ||
                  ((line >= LW'(F2_VIS_FIRST)) && (line <= LW'(F2_VIS_LAST))));

  always_comb begin
    if (samp < SW'(4))                     region = RG_SAV;
    else if (samp < SW'(ACTIVE_WORDS + 4)) region = RG_ACT;
    else if (samp < SW'(ACTIVE_WORDS + 8)) region = RG_EAV;
    else                                   region = RG_BLANK;
  end

  // both codes start on a multiple of four
  assign code_idx = samp[1:0];

endmodule

// File: rtl/vsg_pixel_fetch.sv
module vsg_pixel_fetch
  import vsg_pkg::*;
#(
  parameter int SW           = 11,
  parameter int ACTIVE_WORDS = 1440
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] samp,
  input  logic          vblk,
  input  logic          pix_valid,
  input  logic [31:0]   pix_data,
  output logic          pix_req,
  output logic [7:0]    pair_byte
);

  logic        slot_q;
  logic [31:0] fresh, cur, pair_q;

  // ask during the word that precedes each pair
  assign pix_req = !vblk && (samp >= SW'(3)) && (samp <= SW'(ACTIVE_WORDS - 1)) &&
                   (samp[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) slot_q <= 1'b0;
    else     slot_q <= pix_req;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    localparam logic [7:0] FILL = (g % 2 == 1) ? BLANK_C : BLANK_Y;
    assign fresh[8*g +: 8] = pix_valid ? clip_byte(pix_data[8*g +: 8]) : FILL;
  end

  assign cur = slot_q ? fresh : pair_q;

  always_ff @(posedge clk) begin
    if (rst)         pair_q <= {BLANK_C, BLANK_Y, BLANK_C, BLANK_Y};
    else if (slot_q) pair_q <= fresh;
  end

  always_comb begin
    unique case (samp[1:0])
      2'd0:    pair_byte = cur[31:24];
      2'd1:    pair_byte = cur[23:16];
      2'd2:    pair_byte = cur[15:8];
      default: pair_byte = cur[7:0];
    endcase
  end

endmodule

// File: rtl/vsg_word_mux.sv
module vsg_word_mux
  import vsg_pkg::*;
#(
  parameter int WORDS_PER_LINE  = 1716,
  parameter int LINES_PER_FRAME = 525,
  localparam int SW = $clog2(WORDS_PER_LINE),
  localparam int LW = $clog2(LINES_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  region_e       region,
  input  logic [1:0]    code_idx,
  input  logic [SW-1:0] samp,
  input  logic [LW-1:0] line,
  input  logic          fld,
  input  logic          vblk,
  input  logic [7:0]    pair_byte,
  output logic [7:0]    vid_data,
  output logic [SW-1:0] dbg_samp,
  output logic [LW-1:0] dbg_line
);

  logic [7:0] blank, word;

  assign blank = samp[0] ? BLANK_Y : BLANK_C;

  always_comb begin
    unique case (region)
      RG_SAV, RG_EAV: begin
        unique case (code_idx)
          2'd0:       word = CODE_HI;
          2'd1, 2'd2: word = CODE_LO;
          default:    word = status_word(fld, vblk, region == RG_EAV);
        endcase
      end
      RG_ACT:  word = vblk ? blank : pair_byte;
      default: word = blank;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_data <= BLANK_Y;
      dbg_samp <= SW'(WORDS_PER_LINE - 1);
      dbg_line <= LW'(LINES_PER_FRAME - 1);
    end else begin
      vid_data <= word;
      dbg_samp <= samp;
      dbg_line <= line;
    end
  end

endmodule

// File: rtl/vid_stream_gen.sv
module vid_stream_gen
  import vsg_pkg::*;
#(
  parameter int WORDS_PER_LINE    = 1716,
  parameter int ACTIVE_WORDS      = 1440,
  parameter int LINES_PER_FRAME   = 525,
  parameter int FIELD2_FIRST_LINE = 263,
  parameter int F1_VIS_FIRST      = 19,
  parameter int F1_VIS_LAST       = 261,
  parameter int F2_VIS_FIRST      = 281,
  parameter int F2_VIS_LAST       = 524
) (
  input  logic                               clk,
  input  logic                               rst,
  output logic                               pix_req,
  input  logic                               pix_valid,
  input  logic [31:0]                        pix_data,
  output logic [7:0]                         vid_data,
  output logic [$clog2(LINES_PER_FRAME)-1:0] dbg_line,
  output logic [$clog2(WORDS_PER_LINE)-1:0]  dbg_samp
);

  localparam int SW = $clog2(WORDS_PER_LINE);
  localparam int LW = $clog2(LINES_PER_FRAME);

  logic [SW-1:0] samp;
  logic [LW-1:0] line;
  logic          fld, vblk;
  region_e       region;
  logic [1:0]    code_idx;
  logic [7:0]    pair_byte;

  vsg_raster #(
    .WORDS_PER_LINE   (WORDS_PER_LINE),
    .ACTIVE_WORDS     (ACTIVE_WORDS),
    .LINES_PER_FRAME  (LINES_PER_FRAME),
    .FIELD2_FIRST_LINE(FIELD2_FIRST_LINE),
    .F1_VIS_FIRST     (F1_VIS_FIRST),
    .F1_VIS_LAST      (F1_VIS_LAST),
    .F2_VIS_FIRST     (F2_VIS_FIRST),
    .F2_VIS_LAST      (F2_VIS_LAST)
  ) i_raster (
    .clk     (clk),
    .rst     (rst),
    .samp    (samp),
    .line    (line),
    .fld     (fld),
    .vblk    (vblk),
    .region  (region),
    .code_idx(code_idx)
  );

  vsg_pixel_fetch #(
    .SW          (SW),
    .ACTIVE_WORDS(ACTIVE_WORDS)
  ) i_fetch (
    .clk      (clk),
    .rst      (rst),
    .samp     (samp),
    .vblk     (vblk),
    .pix_valid(pix_valid),
    .pix_data (pix_data),
    .pix_req  (pix_req),
    .pair_byte(pair_byte)
  );

  vsg_word_mux #(
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME)
  ) i_mux (
    .clk      (clk),
    .rst      (rst),
    .region   (region),
    .code_idx (code_idx),
    .samp     (samp),
    .line     (line),
    .fld      (fld),
    .vblk     (vblk),
    .pair_byte(pair_byte),
    .vid_data (vid_data),
    .dbg_samp (dbg_samp),
    .dbg_line (dbg_line)
  );

endmodule

// File: rtl/vid_stream_gen_chk.sv
module vid_stream_gen_chk #(
  parameter int WORDS_PER_LINE  = 1716,
  parameter int ACTIVE_WORDS    = 1440,
  parameter int LINES_PER_FRAME = 525,
  localparam int SW = $clog2(WORDS_PER_LINE),
  localparam int LW = $clog2(LINES_PER_FRAME)
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_req,
  input logic [7:0]    vid_data,
  input logic [SW-1:0] dbg_samp,
  input logic [LW-1:0] dbg_line
);

  a_r1_samp_step: assert property (@(posedge clk) disable iff (rst)
    (dbg_samp != SW'(WORDS_PER_LINE - 1)) |=> (dbg_samp == SW'($past(dbg_samp) + 1'b1)));

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (dbg_samp == SW'(WORDS_PER_LINE - 1)) |=>
      ((dbg_samp == '0) &&
       (dbg_line == (($past(dbg_line) == LW'(LINES_PER_FRAME - 1)) ? '0
                                                                   : LW'($past(dbg_line) + 1'b1)))));

  a_r3_code_leads_line: assert property (@(posedge clk) disable iff (rst)
    (dbg_samp == SW'(WORDS_PER_LINE - 1)) |=> (vid_data == 8'hFF));

  a_r10_reserved_in_codes: assert property (@(posedge clk) disable iff (rst)
    ((vid_data == 8'h00) || (vid_data == 8'hFF)) |->
      ((dbg_samp < SW'(4)) ||
       ((dbg_samp >= SW'(ACTIVE_WORDS + 4)) && (dbg_samp < SW'(ACTIVE_WORDS + 8)))));

  a_r7_req_slot: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> ((dbg_samp[1:0] == 2'b10) && (dbg_samp <= SW'(ACTIVE_WORDS - 2))));

  a_r7_req_gap: assert property (@(posedge clk) disable iff (rst)
    pix_req |=> !pix_req);

endmodule

bind vid_stream_gen vid_stream_gen_chk #(
  .WORDS_PER_LINE (WORDS_PER_LINE),
  .ACTIVE_WORDS   (ACTIVE_WORDS),
  .LINES_PER_FRAME(LINES_PER_FRAME)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .pix_req (pix_req),
  .vid_data(vid_data),
  .dbg_samp(dbg_samp),
  .dbg_line(dbg_line)
);

// File: tb/test_vid_stream_gen.sv
module test_vid_stream_gen;

  localparam int W   = 40;
  localparam int ACT = 16;
  localparam int L   = 10;
  localparam int F2  = 5;
  localparam int V1F = 1, V1L = 3, V2F = 6, V2L = 8;
  localparam int SW  = $clog2(W);
  localparam int LW  = $clog2(L);
  localparam int FRAMES = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pix_valid = 1'b0;
  logic [31:0]   pix_data = '0;
  logic          pix_req;
  logic [7:0]    vid_data;
  logic [SW-1:0] dbg_samp;
  logic [LW-1:0] dbg_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vid_stream_gen #(
    .WORDS_PER_LINE(W), .ACTIVE_WORDS(ACT), .LINES_PER_FRAME(L),
    .FIELD2_FIRST_LINE(F2), .F1_VIS_FIRST(V1F), .F1_VIS_LAST(V1L),
    .F2_VIS_FIRST(V2F), .F2_VIS_LAST(V2L)
  ) i_vid_stream_gen (
    .clk(clk), .rst(rst), .pix_req(pix_req), .pix_valid(pix_valid),
    .pix_data(pix_data), .vid_data(vid_data), .dbg_line(dbg_line), .dbg_samp(dbg_samp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit visible(input int l);
    return ((l >= V1F) && (l <= V1L)) || ((l >= V2F) && (l <= V2L));
  endfunction

  function automatic int status(input int f, input int v, input int h);
    return 128 + f*64 + v*32 + h*16 + ((v^h)*8) + ((f^h)*4) + ((f^v)*2) + (f^v^h);
  endfunction

  function automatic logic [31:0] pair(input int f, input int l, input int k);
    if (k == 1) return 32'h00FFFF00;
    return {8'(l*8 + k), 8'(64 + l), 8'(f*32 + k), 8'(160 + l + k)};
  endfunction

  function automatic bit drop(input int f, input int l, input int k);
    return (f == 1) && (((l + k) % 3) == 0);
  endfunction

  // expected word plus the requirement it belongs to
  task automatic expect_word(input int f, input int l, input int s,
                             output int exp, output string tag);
    int v, ph, k, raw;
    v = visible(l) ? 0 : 1;
    if ((s < 4) || ((s >= ACT + 4) && (s < ACT + 8))) begin
      case (s % 4)
        0: begin exp = 8'hFF; tag = "R3 code lead"; end
        1, 2: begin exp = 8'h00; tag = "R3 code zero"; end
        default: begin
          exp = status((l >= F2) ? 1 : 0, v, (s >= ACT + 4) ? 1 : 0);
          tag = "R4/R5 status";
        end
      endcase
    end else if ((s < ACT + 4) && (v == 0)) begin
      k = (s - 4) / 4;
      ph = (s - 4) % 4;
      if (drop(f, l, k)) begin
        exp = (ph % 2 == 0) ? 8'h80 : 8'h10;
        tag = "R9 missed pair";
      end else begin
        raw = int'((pair(f, l, k) >> (8 * (3 - ph))) & 32'hFF);
        if (raw == 0)        begin exp = 1;   tag = "R10 clip low"; end
        else if (raw == 255) begin exp = 254; tag = "R10 clip high"; end
        else                 begin exp = raw; tag = "R8 pixel"; end
      end
    end else begin
      exp = (s % 2 == 1) ? 8'h10 : 8'h80;
      tag = "R6 blank";
    end
  endtask

  initial begin
    bit pend;
    int pf, pl, pk;
    int exp;
    string tag;
    pend = 1'b0;
    pf = 0; pl = 0; pk = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset vid_data", vid_data, 8'h10);
    chk("R2 reset dbg_samp", dbg_samp, W - 1);
    chk("R2 reset dbg_line", dbg_line, L - 1);
    chk("R2 reset pix_req", pix_req, 0);
    rst = 1'b0;
    for (int n = 0; n < FRAMES * W * L; n++) begin
      int pos, ln, fr;
      @(negedge clk);
      pos = n % W;
      ln = (n / W) % L;
      fr = n / (W * L);
      chk("R1 dbg_samp", dbg_samp, pos);
      chk("R1 dbg_line", dbg_line, ln);
      expect_word(fr, ln, pos, exp, tag);
      chk(tag, vid_data, exp);
      chk("R7 pix_req", pix_req,
          (visible(ln) && (pos % 4 == 2) && (pos <= ACT - 2)) ? 1 : 0);
      // upstream: answer one cycle after a request
      if (pend) begin
        pix_valid = !drop(pf, pl, pk);
        pix_data = drop(pf, pl, pk) ? 32'hFF00FF00 : pair(pf, pl, pk);
      end else if ((fr == 1) && (n % 3 == 0)) begin
        pix_valid = 1'b1;
        pix_data = 32'hFF00FF00;
      end else begin
        pix_valid = 1'b0;
        pix_data = '0;
      end
      pend = pix_req;
      pf = fr;
      pl = ln;
      pk = (pos - 2) / 4;
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule